// File: doc/BRIEF.md
# Set-Associative Cache Tag Array

This block holds the tag side of a set-associative cache: one tag, one valid bit, one owner field and one recency age for every way of every set. A requester sends commands on a single valid/ready port. A command is a lookup, a fill or an invalidate, with an address and a requester ID. The address splits into a tag, a set index and a byte offset within the line. A lookup compares every way of the indexed set at once. It returns hit, way and owner one cycle later, together with the replacement candidate for that set and the line address that candidate currently holds. A fill places a line and an invalidate removes one. Both take effect at the clock edge on which they are accepted.

Software can narrow replacement to the lowest N ways through a limit register. Lines that already sit in higher ways can still be found, but no new line is placed there. The block keeps a count of resident lines for each requester. It also keeps two running activity totals that model tag-array reads and data-array reads. Data reads are modelled in one of two ways, chosen by a mode input: all ways read together, or one way read after a hit.

Top module: `tsa_tag_store`

## Requirements
- R1: The address splits as tag = addr[31:10], set = addr[9:6] and offset = addr[5:0]. The offset does not affect a lookup, and each set is looked up independently of the others.
- R2: `cmd_op` is 0 for lookup, 1 for fill and 2 for invalidate; 3 does nothing. `rsp_valid` is high for exactly one cycle, the cycle after a lookup is accepted. On a hit it carries `rsp_hit`=1, the matching way and that line's owner. On a miss it carries `rsp_hit`=0 and owner 7, the no-owner code.
- R3: The replacement candidate is the lowest-numbered invalid way below the limit.
- R4: When every way below the limit is valid, the candidate is the least recently used of them. A lookup hit or a fill makes the accessed way the most recent.
- R5: `way_limit` resets to 4. A write of 0 or of a value above 4 is refused. On a refused write `lim_err` is high for the following cycle and the limit keeps its value.
- R6: The replacement candidate is always below the current limit.
- R7: A fill of an address that is already present rewrites the way it occupies. Otherwise the fill uses the candidate way. It sets the line valid and makes the filling requester its owner. The incoming requester's count goes up by one. If the displaced line was valid, its previous owner's count goes down by one.
- R8: An invalidate of a present line clears it and decrements its owner's count. A later lookup of that address misses.
- R9: An invalidate of an absent address changes no line and no count.
- R10: Every accepted lookup adds the current limit to `tag_acc`. Fills and invalidates add nothing.
- R11: With `seq_mode`=0, every lookup adds the limit to `data_acc`. With `seq_mode`=1, a hit adds 1 and a miss adds 0.
- R12: `rsp_vic_addr` is the line address rebuilt from the candidate's stored tag and the set, with the offset bits zero. `rsp_vic_valid` reports whether the candidate way holds a valid line.
- R13: Right after reset all lines are invalid, every count and total is zero, `rsp_valid` is low and `cmd_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be accepted |
| cmd_op | input | 2 | 0 lookup, 1 fill, 2 invalidate |
| cmd_addr | input | 32 | Byte address |
| cmd_req | input | 2 | Requester ID for fills |
| seq_mode | input | 1 | 1 = data read only after a hit |
| lim_wr | input | 1 | Write the way limit |
| lim_val | input | 3 | New way limit |
| way_limit | output | 3 | Current way limit |
| lim_err | output | 1 | Previous limit write refused |
| rsp_valid | output | 1 | Lookup response present |
| rsp_hit | output | 1 | Lookup hit |
| rsp_way | output | 2 | Hit way |
| rsp_owner | output | 3 | Owner of hit line, 7 on miss |
| rsp_victim | output | 2 | Replacement candidate way |
| rsp_vic_valid | output | 1 | Candidate holds a valid line |
| rsp_vic_addr | output | 32 | Line address held by candidate |
| occ | output | 28 | Resident-line counts, 7 bits per requester, requester 0 lowest |
| tag_acc | output | 32 | Tag-array access total |
| data_acc | output | 32 | Data-array access total |

## Verification
The assertions assume that the lines in a set never hold the same tag twice. They also assume that a count is never decremented while it is zero. Both follow only if every placement goes through the fill command, which rewrites a present line instead of duplicating it. The stimulus therefore changes the array only through fills and invalidates on the command port. It also fills addresses that are already present, so that the rewrite path is covered. Limit writes are applied between commands. Each lookup can then be checked against the limit in force when it was accepted.

// File: rtl/tsa_pkg.sv
package tsa_pkg;
  typedef enum logic [1:0] {
    OP_LOOKUP = 2'd0,
    OP_FILL   = 2'd1,
    OP_INVAL  = 2'd2,
    OP_IDLE   = 2'd3
  } tsa_op_e;
endpackage

// File: rtl/tsa_match.sv
module tsa_match #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 22,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [WAYS-1:0][TAG_W-1:0]  tags,
  input  logic [WAYS-1:0]             valid,
  input  logic [TAG_W-1:0]            key,
  output logic                        hit,
  output logic [WAY_W-1:0]            way
);
  logic [WAYS-1:0] eq;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign eq[w] = valid[w] && (tags[w] == key);
  end

  always_comb begin
    hit = |eq;
    way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (eq[w]) way = WAY_W'(w);
    end
  end

  // R7: fills never duplicate a tag, so at most one way matches
  p_single_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(eq));
endmodule

// File: rtl/tsa_victim.sv
module tsa_victim #(
  parameter int WAYS = 4,
  localparam int WAY_W = $clog2(WAYS),
  localparam int LIM_W = $clog2(WAYS + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [WAYS-1:0]             valid,
  input  logic [WAYS-1:0][WAY_W-1:0]  ages,
  input  logic [LIM_W-1:0]            limit,
  output logic [WAY_W-1:0]            victim
);
  logic             found;
  logic [WAY_W-1:0] free_way;
  logic [WAY_W-1:0] old_way;
  logic [WAY_W-1:0] old_age;

  always_comb begin
    found    = 1'b0;
    free_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (!found && (LIM_W'(w) < limit) && !valid[w]) begin
        found    = 1'b1;
        free_way = WAY_W'(w);
      end
    end
    old_way = '0;
    old_age = ages[0];
    for (int w = 1; w < WAYS; w++) begin
      if ((LIM_W'(w) < limit) && (ages[w] > old_age)) begin
        old_way = WAY_W'(w);
        old_age = ages[w];
      end
    end
    victim = found ? free_way : old_way;
  end

  // R6: candidate stays inside the allocatable range
  p_victim_in_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    LIM_W'(victim) < limit);
endmodule

// File: rtl/tsa_occupancy.sv
module tsa_occupancy #(
  parameter int NREQ  = 4,
  parameter int OCC_W = 7,
  localparam int REQ_W = $clog2(NREQ)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        inc_en,
  input  logic [REQ_W-1:0]            inc_id,
  input  logic                        dec_en,
  input  logic [REQ_W-1:0]            dec_id,
  output logic [NREQ-1:0][OCC_W-1:0]  occ
);
  for (genvar r = 0; r < NREQ; r++) begin : g_cnt
    logic             up, dn;
    logic [OCC_W-1:0] cnt_q, cnt_d;

    assign up = inc_en && (inc_id == REQ_W'(r));
    assign dn = dec_en && (dec_id == REQ_W'(r));

    always_comb begin
      cnt_d = cnt_q;
      if (up && !dn) cnt_d = cnt_q + 1'b1;
      if (dn && !up) cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cnt_q <= '0;
      else if (up ^ dn)   cnt_q <= cnt_d;
    end

    assign occ[r] = cnt_q;

    // R7: a displaced owner always had at least one resident line
    p_no_underflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (dn && !up) |-> (cnt_q != '0));
  end
endmodule

// File: rtl/tsa_tag_store.sv
module tsa_tag_store #(
  parameter int ADDR_W = 32,
  parameter int OFFS_W = 6,
  parameter int SETS   = 16,
  parameter int WAYS   = 4,
  parameter int NREQ   = 4,
  parameter int CNT_W  = 32,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int TAG_W = ADDR_W - OFFS_W - SET_W,
  localparam int REQ_W = $clog2(NREQ),
  localparam int OWN_W = REQ_W + 1,
  localparam int LIM_W = $clog2(WAYS + 1),
  localparam int OCC_W = $clog2(SETS * WAYS + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cmd_valid,
  output logic                    cmd_ready,
  input  logic [1:0]              cmd_op,
  input  logic [ADDR_W-1:0]       cmd_addr,
  input  logic [REQ_W-1:0]        cmd_req,
  input  logic                    seq_mode,
  input  logic                    lim_wr,
  input  logic [LIM_W-1:0]        lim_val,
  output logic [LIM_W-1:0]        way_limit,
  output logic                    lim_err,
  output logic                    rsp_valid,
  output logic                    rsp_hit,
  output logic [WAY_W-1:0]        rsp_way,
  output logic [OWN_W-1:0]        rsp_owner,
  output logic [WAY_W-1:0]        rsp_victim,
  output logic                    rsp_vic_valid,
  output logic [ADDR_W-1:0]       rsp_vic_addr,
  output logic [NREQ*OCC_W-1:0]   occ,
  output logic [CNT_W-1:0]        tag_acc,
  output logic [CNT_W-1:0]        data_acc
);
  import tsa_pkg::*;

  localparam logic [OWN_W-1:0] OWN_NONE = '1;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rsync_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i_n = rsync_q[1];

  // storage
  logic [WAYS-1:0][TAG_W-1:0] tag_q [SETS];
  logic [WAYS-1:0]            val_q [SETS];
  logic [WAYS-1:0][OWN_W-1:0] own_q [SETS];
  logic [WAYS-1:0][WAY_W-1:0] age_q [SETS];

  logic             rdy_q;
  logic [LIM_W-1:0] limit_q, limit_d;
  logic             lim_ok, lim_err_q;
  logic [CNT_W-1:0] tag_acc_q, tag_acc_d, data_acc_q, data_acc_d;

  // address split and row read
  tsa_op_e          op;
  logic             acc, is_lk, is_fill, is_inv;
  logic [TAG_W-1:0] a_tag;
  logic [SET_W-1:0] a_set;

  assign op      = tsa_op_e'(cmd_op);
  assign acc     = cmd_valid && rdy_q;
  assign is_lk   = acc && (op == OP_LOOKUP);
  assign is_fill = acc && (op == OP_FILL);
  assign is_inv  = acc && (op == OP_INVAL);
  assign a_tag   = cmd_addr[ADDR_W-1 -: TAG_W];
  assign a_set   = cmd_addr[OFFS_W +: SET_W];

  logic [WAYS-1:0][TAG_W-1:0] row_tag, row_tag_d;
  logic [WAYS-1:0]            row_val, row_val_d;
  logic [WAYS-1:0][OWN_W-1:0] row_own, row_own_d;
  logic [WAYS-1:0][WAY_W-1:0] row_age, row_age_d;

  assign row_tag = tag_q[a_set];
  assign row_val = val_q[a_set];
  assign row_own = own_q[a_set];
  assign row_age = age_q[a_set];

  logic             hit;
  logic [WAY_W-1:0] hit_way, vic_way;

  tsa_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
    .clk(clk), .rst_n(rst_i_n), .tags(row_tag), .valid(row_val),
    .key(a_tag), .hit(hit), .way(hit_way));

  tsa_victim #(.WAYS(WAYS)) u_victim (
    .clk(clk), .rst_n(rst_i_n), .valid(row_val), .ages(row_age),
    .limit(limit_q), .victim(vic_way));

  // row next-state
  logic             row_we, touch;
  logic [WAY_W-1:0] twy;
  logic             inc_en, dec_en;
  logic [REQ_W-1:0] dec_id;

  always_comb begin
    row_tag_d = row_tag;
    row_val_d = row_val;
    row_own_d = row_own;
    row_age_d = row_age;
    row_we    = 1'b0;
    touch     = 1'b0;
    twy       = hit ? hit_way : vic_way;
    inc_en    = 1'b0;
    dec_en    = 1'b0;
    dec_id    = row_own[twy][REQ_W-1:0];
    if (is_lk && hit) begin
      row_we = 1'b1;
      touch  = 1'b1;
    end
    if (is_fill) begin
      row_we         = 1'b1;
      touch          = 1'b1;
      row_tag_d[twy] = a_tag;
      row_val_d[twy] = 1'b1;
      row_own_d[twy] = {1'b0, cmd_req};
      inc_en         = 1'b1;
      dec_en         = row_val[twy];
    end
    if (is_inv && hit) begin
      row_we         = 1'b1;
      row_val_d[twy] = 1'b0;
      row_own_d[twy] = OWN_NONE;
      dec_en         = 1'b1;
    end
    if (touch) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == twy)              row_age_d[w] = '0;
        else if (row_age[w] < row_age[twy]) row_age_d[w] = row_age[w] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      for (int s = 0; s < SETS; s++) begin
        val_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) begin
          own_q[s][w] <= OWN_NONE;
          age_q[s][w] <= WAY_W'(w);
        end
      end
    end else if (row_we) begin
      val_q[a_set] <= row_val_d;
      own_q[a_set] <= row_own_d;
      age_q[a_set] <= row_age_d;
    end
  end

  always_ff @(posedge clk) begin
    if (row_we) tag_q[a_set] <= row_tag_d;
  end

  // requester occupancy
  logic [NREQ-1:0][OCC_W-1:0] occ_w;
  tsa_occupancy #(.NREQ(NREQ), .OCC_W(OCC_W)) u_occ (
    .clk(clk), .rst_n(rst_i_n), .inc_en(inc_en), .inc_id(cmd_req),
    .dec_en(dec_en), .dec_id(dec_id), .occ(occ_w));
  assign occ = occ_w;

  // way limit and access totals
  always_comb begin
    lim_ok     = (lim_val != '0) && (lim_val <= LIM_W'(WAYS));
    limit_d    = (lim_wr && lim_ok) ? lim_val : limit_q;
    tag_acc_d  = tag_acc_q + CNT_W'(limit_q);
    data_acc_d = data_acc_q + (seq_mode ? CNT_W'(hit) : CNT_W'(limit_q));
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      rdy_q      <= 1'b0;
      limit_q    <= LIM_W'(WAYS);
      lim_err_q  <= 1'b0;
      tag_acc_q  <= '0;
      data_acc_q <= '0;
    end else begin
      rdy_q     <= 1'b1;
      limit_q   <= limit_d;
      lim_err_q <= lim_wr && !lim_ok;
      if (is_lk) begin
        tag_acc_q  <= tag_acc_d;
        data_acc_q <= data_acc_d;
      end
    end
  end

  // lookup response
  logic                rsp_valid_q, rsp_hit_q, rsp_vv_q;
  logic [WAY_W-1:0]    rsp_way_q, rsp_vic_q;
  logic [OWN_W-1:0]    rsp_own_q;
  logic [ADDR_W-1:0]   rsp_va_q;

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) rsp_valid_q <= 1'b0;
    else          rsp_valid_q <= is_lk;
  end

  always_ff @(posedge clk) begin
    if (is_lk) begin
      rsp_hit_q <= hit;
      rsp_way_q <= hit ? hit_way : '0;
      rsp_own_q <= hit ? row_own[hit_way] : OWN_NONE;
      rsp_vic_q <= vic_way;
      rsp_vv_q  <= row_val[vic_way];
      rsp_va_q  <= {row_tag[vic_way], a_set, {OFFS_W{1'b0}}};
    end
  end

  assign cmd_ready     = rdy_q;
  assign way_limit     = limit_q;
  assign lim_err       = lim_err_q;
  assign rsp_valid     = rsp_valid_q;
  assign rsp_hit       = rsp_hit_q;
  assign rsp_way       = rsp_way_q;
  assign rsp_owner     = rsp_own_q;
  assign rsp_victim    = rsp_vic_q;
  assign rsp_vic_valid = rsp_vv_q;
  assign rsp_vic_addr  = rsp_va_q;
  assign tag_acc       = tag_acc_q;
  assign data_acc      = data_acc_q;

  // R5: limit never leaves the legal range
  p_limit_legal_r5: assert property (@(posedge clk) disable iff (!rst_i_n)
    (limit_q != '0) && (limit_q <= LIM_W'(WAYS)));
  // R2: a response only follows an accepted lookup
  p_rsp_after_lookup_r2: assert property (@(posedge clk) disable iff (!rst_i_n)
    rsp_valid_q |-> $past(is_lk));
  // R2: a hit always reports a real owner
  p_hit_has_owner_r2: assert property (@(posedge clk) disable iff (!rst_i_n)
    (rsp_valid_q && rsp_hit_q) |-> (rsp_own_q != OWN_NONE));
  // R10: tag total grows by the limit in force
  p_tag_total_r10: assert property (@(posedge clk) disable iff (!rst_i_n)
    is_lk |=> (tag_acc_q == $past(tag_acc_q) + CNT_W'($past(limit_q))));
  // R10: totals hold still without a lookup
  p_totals_idle_r10: assert property (@(posedge clk) disable iff (!rst_i_n)
    !is_lk |=> ($stable(tag_acc_q) && $stable(data_acc_q)));
  // R9: invalidating an absent line leaves the counts alone
  p_inval_miss_r9: assert property (@(posedge clk) disable iff (!rst_i_n)
    (is_inv && !hit) |=> $stable(occ_w));
endmodule

// File: tb/tsa_tag_store_tb_top.sv
`timescale 1ns/1ps
module tsa_tag_store_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid;
  logic        cmd_ready;
  logic [1:0]  cmd_op;
  logic [31:0] cmd_addr;
  logic [1:0]  cmd_req;
  logic        seq_mode;
  logic        lim_wr;
  logic [2:0]  lim_val;
  logic [2:0]  way_limit;
  logic        lim_err;
  logic        rsp_valid, rsp_hit, rsp_vic_valid;
  logic [1:0]  rsp_way, rsp_victim;
  logic [2:0]  rsp_owner;
  logic [31:0] rsp_vic_addr;
  logic [27:0] occ;
  logic [31:0] tag_acc, data_acc;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  tsa_tag_store dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_req(cmd_req),
    .seq_mode(seq_mode), .lim_wr(lim_wr), .lim_val(lim_val),
    .way_limit(way_limit), .lim_err(lim_err), .rsp_valid(rsp_valid),
    .rsp_hit(rsp_hit), .rsp_way(rsp_way), .rsp_owner(rsp_owner),
    .rsp_victim(rsp_victim), .rsp_vic_valid(rsp_vic_valid),
    .rsp_vic_addr(rsp_vic_addr), .occ(occ), .tag_acc(tag_acc),
    .data_acc(data_acc));

  // row: op(2) tag(8) req_or_limit(3) hit(1) way(2) owner(3) victim(2)
  // op 0 lookup, 1 fill, 2 invalidate, 3 limit write; all rows use set 2
  localparam int NV = 20;
  localparam logic [20:0] VEC [NV] = '{
    {2'd0, 8'd1, 3'd0, 1'b0, 2'd0, 3'd7, 2'd0},
    {2'd1, 8'd1, 3'd0, 1'b0, 2'd0, 3'd0, 2'd0},
    {2'd0, 8'd1, 3'd0, 1'b1, 2'd0, 3'd0, 2'd1},
    {2'd1, 8'd2, 3'd1, 1'b0, 2'd0, 3'd0, 2'd0},
    {2'd1, 8'd3, 3'd2, 1'b0, 2'd0, 3'd0, 2'd0},
    {2'd1, 8'd4, 3'd3, 1'b0, 2'd0, 3'd0, 2'd0},
    {2'd0, 8'd1, 3'd0, 1'b1, 2'd0, 3'd0, 2'd0},
    {2'd0, 8'd5, 3'd0, 1'b0, 2'd0, 3'd7, 2'd1},
    {2'd3, 8'd0, 3'd2, 1'b0, 2'd0, 3'd0, 2'd0},
    {2'd0, 8'd5, 3'd0, 1'b0, 2'd0, 3'd7, 2'd1},
    {2'd1, 8'd5, 3'd0, 1'b0, 2'd0, 3'd0, 2'd0},
    {2'd0, 8'd6, 3'd0, 1'b0, 2'd0, 3'd7, 2'd0},
    {2'd1, 8'd6, 3'd2, 1'b0, 2'd0, 3'd0, 2'd0},
    {2'd2, 8'd3, 3'd0, 1'b0, 2'd0, 3'd0, 2'd0},
    {2'd2, 8'd3, 3'd0, 1'b0, 2'd0, 3'd0, 2'd0},
    {2'd0, 8'd3, 3'd0, 1'b0, 2'd0, 3'd7, 2'd1},
    {2'd3, 8'd0, 3'd4, 1'b0, 2'd0, 3'd0, 2'd0},
    {2'd0, 8'd3, 3'd0, 1'b0, 2'd0, 3'd7, 2'd2},
    {2'd0, 8'd5, 3'd0, 1'b1, 2'd1, 3'd0, 2'd2},
    {2'd0, 8'd4, 3'd0, 1'b1, 2'd3, 3'd3, 2'd2}
  };

  int          exp_tag  = 0;
  int          exp_data = 0;
  int          lim_m    = 4;

  function automatic logic [31:0] mk(input int t, input int s);
    return (32'(t) << 10) | (32'(s) << 6);
  endfunction

  function automatic int occ_of(input int r);
    return int'(occ[r*7 +: 7]);
  endfunction

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] op, input logic [31:0] a, input logic [1:0] rq);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_req = rq;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic setlim(input logic [2:0] v);
    lim_wr = 1'b1; lim_val = v;
    @(negedge clk);
    lim_wr = 1'b0;
    if (v >= 1 && v <= 4) lim_m = int'(v);
  endtask

  task automatic look(input logic [31:0] a, input logic exp_hit, input string tagname);
    issue(2'd0, a, 2'd0);
    exp_tag  += lim_m;
    exp_data += seq_mode ? int'(exp_hit) : lim_m;
    chk({tagname, " rsp_valid"}, 32'(rsp_valid), 32'd1);
    chk({tagname, " hit"}, 32'(rsp_hit), 32'(exp_hit));
    chk("R10 tag_acc", tag_acc, 32'(exp_tag));
    chk("R11 data_acc", data_acc, 32'(exp_data));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 2'd3; cmd_addr = '0;
    cmd_req = '0; seq_mode = 1'b0; lim_wr = 1'b0; lim_val = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R13 reset state
    chk("R13 cmd_ready", 32'(cmd_ready), 32'd1);
    chk("R13 rsp_valid", 32'(rsp_valid), 32'd0);
    chk("R13 occ", 32'(occ), 32'd0);
    chk("R13 tag_acc", tag_acc, 32'd0);
    chk("R13 data_acc", data_acc, 32'd0);
    chk("R5 reset limit", 32'(way_limit), 32'd4);
    chk("R5 reset lim_err", 32'(lim_err), 32'd0);

    // table walk: R2 R3 R4 R6 R7 R8 R9 R10 R11 R12
    for (int i = 0; i < NV; i++) begin
      logic [1:0] op;
      logic [7:0] tg;
      logic [2:0] rq;
      logic       eh;
      logic [1:0] ew, ev;
      logic [2:0] eo;
      {op, tg, rq, eh, ew, eo, ev} = VEC[i];
      if (op == 2'd3) begin
        setlim(rq);
        chk("R5 limit accepted", 32'(way_limit), 32'(rq));
      end else if (op == 2'd0) begin
        look(mk(int'(tg), 2), eh, "R2");
        if (eh) chk("R2 way", 32'(rsp_way), 32'(ew));
        chk("R2 owner", 32'(rsp_owner), 32'(eo));
        chk("R3/R4/R6 victim", 32'(rsp_victim), 32'(ev));
        if (i == 0) chk("R12 vic_valid empty", 32'(rsp_vic_valid), 32'd0);
        if (i == 7) begin
          chk("R12 vic_valid", 32'(rsp_vic_valid), 32'd1);
          chk("R12 vic_addr", rsp_vic_addr, mk(2, 2));
        end
      end else begin
        issue(op, mk(int'(tg), 2), rq[1:0]);
        @(negedge clk);
        chk("R2 no rsp on fill/inval", 32'(rsp_valid), 32'd0);
        chk("R10 tag_acc unchanged", tag_acc, 32'(exp_tag));
        if (i == 10) begin
          chk("R7 occ0", 32'(occ_of(0)), 32'd2);
          chk("R7 occ1 displaced", 32'(occ_of(1)), 32'd0);
        end
        if (i == 13 || i == 14) begin
          chk(i == 13 ? "R8 occ2" : "R9 occ2", 32'(occ_of(2)), 32'd1);
          chk("R9 occ0", 32'(occ_of(0)), 32'd1);
          chk("R9 occ3", 32'(occ_of(3)), 32'd1);
        end
      end
    end

    // R1 offset ignored, sets independent
    look(mk(5, 2) | 32'h2A, 1'b1, "R1 offset");
    chk("R1 offset way", 32'(rsp_way), 32'd1);
    look(mk(5, 3), 1'b0, "R1 other set");
    chk("R1 other set victim", 32'(rsp_victim), 32'd0);

    // R11 sequential data accesses
    seq_mode = 1'b1;
    look(mk(5, 2), 1'b1, "R11 seq hit");
    look(mk(9, 2), 1'b0, "R11 seq miss");
    seq_mode = 1'b0;

    // R5 refused limits
    setlim(3'd0);
    chk("R5 zero refused err", 32'(lim_err), 32'd1);
    chk("R5 zero refused limit", 32'(way_limit), 32'd4);
    setlim(3'd5);
    chk("R5 five refused err", 32'(lim_err), 32'd1);
    chk("R5 five refused limit", 32'(way_limit), 32'd4);
    setlim(3'd1);
    chk("R5 one accepted err", 32'(lim_err), 32'd0);
    look(mk(9, 2), 1'b0, "R6 limit one");
    chk("R6 victim way0", 32'(rsp_victim), 32'd0);
    setlim(3'd4);

    // R7 refill of a present line rewrites its way
    issue(2'd1, mk(5, 2), 2'd3);
    chk("R7 refill occ0", 32'(occ_of(0)), 32'd0);
    chk("R7 refill occ3", 32'(occ_of(3)), 32'd2);
    look(mk(5, 2), 1'b1, "R7 refill");
    chk("R7 refill way", 32'(rsp_way), 32'd1);
    chk("R7 refill owner", 32'(rsp_owner), 32'd3);

    // R8 invalidate then miss
    issue(2'd2, mk(5, 2), 2'd0);
    chk("R8 occ3", 32'(occ_of(3)), 32'd1);
    look(mk(5, 2), 1'b0, "R8 after invalidate");
    chk("R8 owner", 32'(rsp_owner), 32'd7);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule